// File: doc/BRIEF.md
# Multi-Level Vectored Interrupt Arbiter

This block gathers interrupt requests from many sources. The requests are grouped into eight priority levels, and each level has 32 request bits. A request bit is set by a one-cycle pulse on its line of `req_set`. The bit then stays set until it is granted. The block compares the held requests with the processor's current priority and raises `irq_pending` whenever some level strictly above that priority holds a request.

When the processor acknowledges, the block searches the levels from highest to lowest and picks the lowest-numbered set bit in the first eligible level. It clears that bit and, one cycle later, returns the vector with a valid pulse. Each of the 256 request locations has an entry in a vector table. The entry holds either a stored vector or a mark that says the device supplies its own vector; in the second case the block samples `dev_vec` during the acknowledge cycle. The table is loaded through a write port addressed by location. The top request bit of each level from 1 to 7 is reserved for programmed interrupts, and all seven of these bits return one common fixed vector.

Top module: `vec_irq_arbiter`

## Requirements
- R1: Location `loc` (0..255) is level `loc[7:5]`, bit `loc[4:0]`. A pulse on `req_set[loc]` sets that request. The request stays set until it is granted.
- R2: `irq_pending` is high exactly when some level L with L > `cur_prio` holds at least one set request. Requests at or below `cur_prio` never raise it.
- R3: An acknowledge grants from the highest eligible level. Within that level it grants the lowest-numbered set bit.
- R4: The granted request is cleared on the edge that accepts the acknowledge. All other requests are kept.
- R5: `ack_valid` pulses high in the cycle after each cycle with `ack_req` high, and is low otherwise. `ack_vec` is valid while `ack_valid` is high.
- R6: If the granted location is marked device-supplied (`tbl_dev`=1 when it was written), the vector is the `dev_vec` value present in the acknowledge cycle. Otherwise the vector is the stored table vector.
- R7: If no level above `cur_prio` has a request when `ack_req` is high, the returned vector is 0 and no request is cleared.
- R8: A table write (`tbl_we`=1) stores `tbl_vec` and `tbl_dev` for location `tbl_loc`, split as in R1. The new entry is used by acknowledges in later cycles.
- R9: Bit 31 of levels 1 to 7 always returns the fixed vector 0o240, whatever has been written to those table locations.
- R10: A `req_set` pulse on the same location that is granted in that same cycle leaves the request set.
- R11: After reset, no request is held, `irq_pending` is low and `ack_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_set | input | 256 | One-cycle set pulses, one per request location |
| cur_prio | input | 3 | Current processor priority |
| irq_pending | output | 1 | A request above `cur_prio` is waiting |
| ack_req | input | 1 | Acknowledge strobe |
| dev_vec | input | 16 | Vector supplied by the device, sampled while `ack_req` is high |
| ack_valid | output | 1 | Vector returned this cycle |
| ack_vec | output | 16 | Returned vector |
| tbl_we | input | 1 | Table write enable |
| tbl_loc | input | 8 | Table location to write |
| tbl_vec | input | 16 | Vector to store |
| tbl_dev | input | 1 | 1 marks the location as device-supplied |

## Verification
On every cycle the assertions check the following: the one-cycle acknowledge latency, zero vectors when nothing is eligible, that at most one location is granted, that a grant clears its bit unless a set pulse arrives in the same cycle, that pending stays silent at the top priority, and that programmed-interrupt locations return the fixed vector. Other properties depend on the contents of the table and on the history of requests, so only the bench scenarios can show them. These are the exact search order across levels and bits, the choice between table and device vectors, and the agreement of pending with the full request set. The bench checks them against a reference model while directed and random requests, priorities and table writes are applied.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    SRC_TABLE  = 1'b0,
    SRC_DEVICE = 1'b1
  } vec_src_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_req_store.sv
module irq_req_store #(
  parameter int N_LOC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LOC-1:0] set_i,
  input  logic             grant_en_i,
  input  logic [N_LOC-1:0] grant_oh_i,
  output logic [N_LOC-1:0] req_o
);
  logic [N_LOC-1:0] req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (grant_en_i) req_d = req_d & ~grant_oh_i;
    req_d = req_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  // R4: the granted bit is gone after the edge when no set pulse coincides
  assert_grant_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_en_i && ((grant_oh_i & set_i) == '0)) |=> ((req_q & $past(grant_oh_i)) == '0));
  // R10: a coinciding set pulse keeps the granted bit alive
  assert_collision_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_en_i && ((grant_oh_i & set_i) != '0)) |=> ((req_q & $past(grant_oh_i)) != '0));
  // R1: a set pulse always leaves the bit set
  assert_set_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LVL = 8,
  parameter int N_BIT = 32,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int BIT_W = $clog2(N_BIT),
  localparam int N_LOC = N_LVL * N_BIT,
  localparam int LOC_W = LVL_W + BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LOC-1:0] req_i,
  input  logic [LVL_W-1:0] prio_i,
  output logic             found_o,
  output logic [LOC_W-1:0] loc_o,
  output logic [N_LOC-1:0] grant_oh_o
);
  logic [LVL_W-1:0] lvl_sel;
  logic [BIT_W-1:0] bit_sel;
  logic [N_BIT-1:0] word;

  always_comb begin
    found_o = 1'b0;
    lvl_sel = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if ((LVL_W'(l) > prio_i) && (req_i[l*N_BIT +: N_BIT] != '0)) begin
        found_o = 1'b1;
        lvl_sel = LVL_W'(l);
      end
    end
    word    = req_i[lvl_sel*N_BIT +: N_BIT];
    bit_sel = '0;
    for (int b = N_BIT - 1; b >= 0; b--) begin
      if (word[b]) bit_sel = BIT_W'(b);
    end
    loc_o = {lvl_sel, bit_sel};
    grant_oh_o = '0;
    grant_oh_o[loc_o] = found_o;
  end

  // R3: at most one location granted at a time
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh_o));
  // R3: the grant always lands on a held request
  assert_grant_is_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> ((grant_oh_o & req_i) == grant_oh_o));
  // R2: nothing is eligible at the top priority
  assert_top_prio_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_i == '1) |-> !found_o);
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table
  import irq_arb_pkg::*;
#(
  parameter int              N_LVL    = 8,
  parameter int              N_BIT    = 32,
  parameter int              VEC_W    = 16,
  parameter bit              PIRQ_EN  = 1'b1,
  parameter logic [VEC_W-1:0] PIRQ_VEC = 16'o240,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int BIT_W = $clog2(N_BIT),
  localparam int N_LOC = N_LVL * N_BIT,
  localparam int LOC_W = LVL_W + BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [LOC_W-1:0] wr_loc_i,
  input  logic [VEC_W-1:0] wr_vec_i,
  input  vec_src_e         wr_src_i,
  input  logic [LOC_W-1:0] rd_loc_i,
  output logic [VEC_W-1:0] rd_vec_o,
  output vec_src_e         rd_src_o
);
  logic [VEC_W-1:0] vec_mem [N_LOC];
  vec_src_e         src_q   [N_LOC];
  logic             is_pirq;

  always_ff @(posedge clk) begin
    if (wr_en_i) vec_mem[wr_loc_i] <= wr_vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LOC; i++) src_q[i] <= SRC_TABLE;
    end else if (wr_en_i) begin
      src_q[wr_loc_i] <= wr_src_i;
    end
  end

  generate
    if (PIRQ_EN) begin : g_pirq
      assign is_pirq = (rd_loc_i[BIT_W-1:0] == '1) && (rd_loc_i[LOC_W-1:BIT_W] != '0);
    end else begin : g_no_pirq
      assign is_pirq = 1'b0;
    end
  endgenerate

  always_comb begin
    if (is_pirq) begin
      rd_vec_o = PIRQ_VEC;
      rd_src_o = SRC_TABLE;
    end else begin
      rd_vec_o = vec_mem[rd_loc_i];
      rd_src_o = src_q[rd_loc_i];
    end
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int               N_LVL    = 8,
  parameter int               N_BIT    = 32,
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] PIRQ_VEC = 16'o240,
  localparam int LVL_W = $clog2(N_LVL),
  localparam int BIT_W = $clog2(N_BIT),
  localparam int N_LOC = N_LVL * N_BIT,
  localparam int LOC_W = LVL_W + BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LOC-1:0] req_set,
  input  logic [LVL_W-1:0] cur_prio,
  output logic             irq_pending,
  input  logic             ack_req,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vec,
  input  logic             tbl_we,
  input  logic [LOC_W-1:0] tbl_loc,
  input  logic [VEC_W-1:0] tbl_vec,
  input  logic             tbl_dev
);
  logic             rst_s;
  logic [N_LOC-1:0] req;
  logic [N_LOC-1:0] grant_oh;
  logic             found;
  logic [LOC_W-1:0] win_loc;
  logic [VEC_W-1:0] rd_vec;
  vec_src_e         rd_src;

  logic             vld_q, vld_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [LOC_W-1:0] loc_q, loc_d;
  logic             hit_q, hit_d;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  irq_req_store #(.N_LOC(N_LOC)) u_store (
    .clk        (clk),
    .rst_n      (rst_s),
    .set_i      (req_set),
    .grant_en_i (ack_req),
    .grant_oh_i (grant_oh),
    .req_o      (req)
  );

  irq_prio_pick #(.N_LVL(N_LVL), .N_BIT(N_BIT)) u_pick (
    .clk        (clk),
    .rst_n      (rst_s),
    .req_i      (req),
    .prio_i     (cur_prio),
    .found_o    (found),
    .loc_o      (win_loc),
    .grant_oh_o (grant_oh)
  );

  irq_vec_table #(.N_LVL(N_LVL), .N_BIT(N_BIT), .VEC_W(VEC_W),
                  .PIRQ_EN(1'b1), .PIRQ_VEC(PIRQ_VEC)) u_table (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en_i  (tbl_we),
    .wr_loc_i (tbl_loc),
    .wr_vec_i (tbl_vec),
    .wr_src_i (tbl_dev ? SRC_DEVICE : SRC_TABLE),
    .rd_loc_i (win_loc),
    .rd_vec_o (rd_vec),
    .rd_src_o (rd_src)
  );

  assign irq_pending = found;

  always_comb begin
    vld_d = ack_req;
    vec_d = vec_q;
    loc_d = loc_q;
    hit_d = hit_q;
    if (ack_req) begin
      hit_d = found;
      loc_d = win_loc;
      if (!found)                  vec_d = '0;
      else if (rd_src == SRC_DEVICE) vec_d = dev_vec;
      else                         vec_d = rd_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= 1'b0;
      vec_q <= '0;
      loc_q <= '0;
      hit_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (ack_req) begin
        vec_q <= vec_d;
        loc_q <= loc_d;
        hit_q <= hit_d;
      end
    end
  end

  assign ack_valid = vld_q;
  assign ack_vec   = vec_q;

  // R5: one-cycle acknowledge latency
  assert_ack_latency_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ack_req |=> ack_valid);
  assert_no_spurious_ack_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !ack_req |=> !ack_valid);
  // R7: nothing eligible gives vector zero
  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_req && !irq_pending) |=> (ack_vec == '0));
  // R9: programmed-interrupt locations return the fixed vector
  assert_pirq_vector_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_valid && hit_q && (loc_q[BIT_W-1:0] == '1) && (loc_q[LOC_W-1:BIT_W] != '0))
      |-> (ack_vec == PIRQ_VEC));
endmodule

// File: tb/vec_irq_arbiter_test.sv
`timescale 1ns/1ps
module vec_irq_arbiter_test;
  localparam logic [15:0] PIRQ = 16'o240;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] req_set;
  logic [2:0]   cur_prio;
  logic         irq_pending;
  logic         ack_req;
  logic [15:0]  dev_vec;
  logic         ack_valid;
  logic [15:0]  ack_vec;
  logic         tbl_we;
  logic [7:0]   tbl_loc;
  logic [15:0]  tbl_vec;
  logic         tbl_dev;

  int checks = 0;
  int failures = 0;

  logic [255:0] mreq;
  logic [15:0]  mvec [256];
  logic         mdev [256];

  always #4 clk = ~clk;

  vec_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .cur_prio(cur_prio),
    .irq_pending(irq_pending), .ack_req(ack_req), .dev_vec(dev_vec),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .tbl_we(tbl_we),
    .tbl_loc(tbl_loc), .tbl_vec(tbl_vec), .tbl_dev(tbl_dev)
  );

  function automatic int pick(input logic [255:0] r, input int p);
    for (int l = 7; l > p; l--)
      for (int b = 0; b < 32; b++)
        if (r[l*32+b]) return l*32 + b;
    return -1;
  endfunction

  function automatic logic [15:0] vec_of(input int loc, input logic [15:0] dv);
    if (loc < 0) return 16'h0;
    if ((loc % 32 == 31) && (loc / 32 >= 1)) return PIRQ;
    if (mdev[loc]) return dv;
    return mvec[loc];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle; checks are taken 2 ns after the edge
  task automatic step(input string tag, input logic [255:0] set, input logic ack,
                      input logic [15:0] dv, input logic [2:0] p,
                      input logic we, input logic [7:0] wl,
                      input logic [15:0] wv, input logic wd);
    int win;
    logic [15:0] ev;
    logic [255:0] gm;
    req_set = set; ack_req = ack; dev_vec = dv; cur_prio = p;
    tbl_we = we; tbl_loc = wl; tbl_vec = wv; tbl_dev = wd;
    win = pick(mreq, p);
    ev  = vec_of(win, dv);
    gm  = '0;
    if (ack && win >= 0) gm[win] = 1'b1;
    @(posedge clk); #2;
    mreq = (mreq & ~gm) | set;
    if (we) begin mvec[wl] = wv; mdev[wl] = wd; end
    chk({tag, " R5 valid"}, 32'(ack_valid), 32'(ack));
    if (ack) chk({tag, " vector"}, 32'(ack_vec), 32'(ev));
    chk({tag, " R2 pending"}, 32'(irq_pending), 32'(pick(mreq, p) >= 0));
    req_set = '0; ack_req = 1'b0; tbl_we = 1'b0;
  endtask

  function automatic logic [255:0] one(input int loc);
    logic [255:0] v = '0;
    v[loc] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_set = '0; cur_prio = 3'd0; ack_req = 1'b0; dev_vec = '0;
    tbl_we = 1'b0; tbl_loc = '0; tbl_vec = '0; tbl_dev = 1'b0;
    mreq = '0;
    for (int i = 0; i < 256; i++) begin mvec[i] = '0; mdev[i] = 1'b0; end
    repeat (3) @(posedge clk); #2;
    chk("R11 pending in reset", 32'(irq_pending), 0);
    chk("R11 valid in reset", 32'(ack_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;
    chk("R11 pending after reset", 32'(irq_pending), 0);
    step("R7 R11 empty ack", '0, 1'b1, 16'h1111, 3'd0, 0, 0, 0, 0);

    // R8: load table, vector = 4*loc, some locations device-supplied
    for (int i = 0; i < 256; i++)
      step("R8 load", '0, 1'b0, 0, 3'd0, 1'b1, 8'(i), 16'(i*4), (i % 5) == 3);

    // R1 R3: several levels and bits
    step("R1 set", one(5*32+9) | one(5*32+2) | one(3*32+0), 0, 0, 3'd0, 0, 0, 0, 0);
    step("R3 R8 lvl5 bit2", '0, 1'b1, 16'h0abc, 3'd0, 0, 0, 0, 0);
    step("R3 R4 lvl5 bit9", '0, 1'b1, 16'h0abc, 3'd0, 0, 0, 0, 0);
    // R2 R7: priority gate
    step("R2 gate", '0, 1'b0, 0, 3'd3, 0, 0, 0, 0);
    step("R7 gated ack", '0, 1'b1, 16'h0abc, 3'd3, 0, 0, 0, 0);
    step("R2 open", '0, 1'b0, 0, 3'd2, 0, 0, 0, 0);
    step("R3 lvl3 bit0", '0, 1'b1, 0, 3'd2, 0, 0, 0, 0);
    // R6: device-supplied location 163
    step("R6 set", one(163), 0, 0, 3'd0, 0, 0, 0, 0);
    step("R6 device vec", '0, 1'b1, 16'o1234, 3'd0, 0, 0, 0, 0);
    chk("R6 device vec value", 32'(ack_vec), 32'(16'o1234));
    // R9: write over a programmed-interrupt location, still fixed
    step("R9 write", '0, 0, 0, 3'd0, 1'b1, 8'(3*32+31), 16'h5555, 1'b1);
    step("R9 set", one(3*32+31), 0, 0, 3'd0, 0, 0, 0, 0);
    step("R9 pirq ack", '0, 1'b1, 16'h7777, 3'd0, 0, 0, 0, 0);
    chk("R9 pirq value", 32'(ack_vec), 32'(PIRQ));
    // R10: set pulse during grant of the same bit
    step("R10 set", one(6*32+4), 0, 0, 3'd0, 0, 0, 0, 0);
    step("R10 collide", one(6*32+4), 1'b1, 0, 3'd0, 0, 0, 0, 0);
    step("R10 regrant", '0, 1'b1, 0, 3'd0, 0, 0, 0, 0);
    chk("R10 regrant vec", 32'(ack_vec), 32'((6*32+4)*4));
    step("R4 empty again", '0, 1'b1, 0, 3'd0, 0, 0, 0, 0);
    chk("R4 R7 drained", 32'(ack_vec), 0);

    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [255:0] s;
      s = '0;
      if ($urandom_range(0, 2) == 0) s[$urandom_range(0, 255)] = 1'b1;
      if ($urandom_range(0, 5) == 0) s[$urandom_range(0, 255)] = 1'b1;
      step("R3 R6 random", s, $urandom_range(0, 2) == 0, 16'($urandom),
           3'($urandom_range(0, 7)), $urandom_range(0, 15) == 0,
           8'($urandom), 16'($urandom), $urandom_range(0, 1) == 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule